// File: doc/BRIEF.md
# Transmit Box Priority Selector

This block decides which of a set of message boxes a frame transmitter sends next. Each box carries a pending-send flag, a format bit (short 11-bit identifier or long 29-bit identifier) and an identifier. The host raises a box's flag with a one-cycle set pulse. The flag then stays high until that box's frame has gone out successfully.

Only boxes whose index is below the programmed box count take part. Among those with a raised flag, the selector offers the winner to the transmitter in the same cycle. The winner is the box whose identifier would win bus arbitration: identifiers are compared from the top bit down, and a 0 bit beats a 1 bit.

When the transmitter accepts the offer, the selector locks the box number in a register and keeps it there until the transmitter reports an outcome. On success the flag is cleared. On failure or lost arbitration the flag is kept, so the box competes again.

Top module: `tx_box_arbiter`

## Requirements
- R1: After reset all pending flags are 0, `busy` is 0, `sel_valid` is 0 and `cur_box` is 0.
- R2: A 1 on bit i of `req_set` at a clock edge makes pending flag i equal to 1 after that edge. The flag stays 1 until a successful completion of box i clears it.
- R3: Only boxes with index below `box_cnt` are candidates. A count above the number of boxes makes every box valid, and a count of 0 leaves no candidate. When `sel_valid` is 1, `sel_idx` is below `box_cnt` and its pending flag is 1.
- R4: Each box has an identifier slot in `box_id`. Box i uses bits [29*i+28 : 29*i]. A short identifier sits in the low 11 bits of its slot. A long identifier fills all 29 bits, and its bits 28..18 are its top 11 bits. A box's format is set by `box_ext[i]`, where 1 means long. Candidates are ranked by their top 11 identifier bits first: a short identifier's 11 bits, or a long identifier's bits 28..18. These bits are compared from the most significant bit down, and the first position where one identifier has 0 and the other has 1 decides in favour of the 0.
- R5: When the top 11 bits are equal, a short identifier beats a long one. Two long identifiers are then ranked by their bits 17..0, again with a 0 bit winning at the first difference from the top.
- R6: Candidates with equal rank (same format and same identifier bits compared) are resolved in favour of the lower box index.
- R7: While `busy` is 0, `sel_valid` and `sel_idx` follow the current pending flags, `box_cnt`, `box_ext` and `box_id` in the same cycle, without a register in between.
- R8: `tx_start` with `sel_valid` = 1 sets `busy` and loads `cur_box` with `sel_idx` at that edge. While `busy` is 1, `sel_valid` is 0 and `cur_box` holds its value.
- R9: `tx_done` with `tx_ok` = 1 while `busy` clears the pending flag of `cur_box` and drops `busy` at the same edge.
- R10: `tx_done` with `tx_ok` = 0 while `busy` drops `busy`, leaves the flag of `cur_box` at 1, and makes that box a candidate again.
- R11: If `req_set` targets `cur_box` at the same edge as a successful completion of that box, the flag stays 1.
- R12: `tx_start` has no effect while `sel_valid` is 0. `tx_done` has no effect on flags or `busy` while `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| box_cnt | input | 5 | Number of valid boxes, counted from box 0 |
| box_ext | input | 16 | Per-box format, 1 = 29-bit identifier |
| box_id | input | 464 | Identifiers, 29 bits per box, box 0 lowest |
| req_set | input | 16 | One-cycle pulses that raise pending flags |
| tx_start | input | 1 | Transmitter takes the offered box |
| tx_done | input | 1 | Transmitter reports the end of an attempt |
| tx_ok | input | 1 | Qualifies `tx_done`: 1 = sent, 0 = failed or lost |
| req_flags | output | 16 | Pending flags, readable by the host |
| sel_valid | output | 1 | A candidate is offered |
| sel_idx | output | 4 | Offered box index |
| busy | output | 1 | A box is being sent |
| cur_box | output | 4 | Box number of the current or last attempt |

## Verification
The embedded properties watch the handshake on every cycle. They check that an accepted start locks the offered index and keeps it stable, that success clears exactly the locked box's flag, and that failure keeps it. They also check that no flag ever falls except through a success, and that any offered index is in range and pending. Whether the offered box really has the best rank cannot be seen by a property. The bench shows this by comparing the offer with its own arithmetic ranking over hundreds of flag, count, format and identifier patterns, including forced ties and short-against-long collisions. It also drains boxes one by one to confirm the send order.

// File: rtl/tba_pkg.sv
package tba_pkg;
  localparam int ID_W  = 29;
  localparam int STD_W = 11;
  localparam int LOW_W = ID_W - STD_W;
  localparam int KEY_W = ID_W + 1;

  // Rank key: smaller value wins arbitration.
  // {top 11 bits, format bit (short = 0), low 18 bits (0 for short)}
  function automatic logic [KEY_W-1:0] rank_key(input logic ext, input logic [ID_W-1:0] id);
    logic [KEY_W-1:0] k;
    if (ext) k = {id[ID_W-1 -: STD_W], 1'b1, id[LOW_W-1:0]};
    else     k = {id[STD_W-1:0], 1'b0, {LOW_W{1'b0}}};
    return k;
  endfunction
endpackage

// File: rtl/tba_req_store.sv
module tba_req_store #(
  parameter int NBOX = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NBOX-1:0] set_mask,
  input  logic [NBOX-1:0] clr_mask,
  output logic [NBOX-1:0] flags
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~clr_mask) | set_mask;
  end

  // R2
  set_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_mask != '0) |=> ((flags & $past(set_mask)) == $past(set_mask)));

  // R9
  clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~flags & $past(flags) & ~$past(clr_mask)) == '0));
endmodule

// File: rtl/tba_key_gen.sv
module tba_key_gen
  import tba_pkg::*;
#(
  parameter int NBOX = 16,
  localparam int CNT_W = $clog2(NBOX + 1)
) (
  input  logic [NBOX-1:0]       flags,
  input  logic [CNT_W-1:0]      box_cnt,
  input  logic [NBOX-1:0]       box_ext,
  input  logic [NBOX*ID_W-1:0]  box_id,
  output logic [NBOX-1:0]       cand,
  output logic [NBOX*KEY_W-1:0] keys
);
  for (genvar i = 0; i < NBOX; i++) begin : g_box
    assign cand[i] = flags[i] && (i < int'(box_cnt));
    assign keys[i*KEY_W +: KEY_W] = rank_key(box_ext[i], box_id[i*ID_W +: ID_W]);
  end
endmodule

// File: rtl/tba_scan.sv
module tba_scan
  import tba_pkg::*;
#(
  parameter int NBOX = 16,
  localparam int IDX_W = $clog2(NBOX)
) (
  input  logic [NBOX-1:0]       cand,
  input  logic [NBOX*KEY_W-1:0] keys,
  output logic                  win_valid,
  output logic [IDX_W-1:0]      win_idx
);
  logic [KEY_W-1:0] best;

  // Ascending scan with strict compare: ties keep the lower index.
  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    best      = '1;
    for (int i = 0; i < NBOX; i++) begin
      if (cand[i] && (!win_valid || keys[i*KEY_W +: KEY_W] < best)) begin
        win_valid = 1'b1;
        win_idx   = IDX_W'(i);
        best      = keys[i*KEY_W +: KEY_W];
      end
    end
  end
endmodule

// File: rtl/tx_box_arbiter.sv
module tx_box_arbiter
  import tba_pkg::*;
#(
  parameter int NBOX = 16,
  localparam int IDX_W = $clog2(NBOX),
  localparam int CNT_W = $clog2(NBOX + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [CNT_W-1:0]      box_cnt,
  input  logic [NBOX-1:0]       box_ext,
  input  logic [NBOX*ID_W-1:0]  box_id,
  input  logic [NBOX-1:0]       req_set,
  input  logic                  tx_start,
  input  logic                  tx_done,
  input  logic                  tx_ok,
  output logic [NBOX-1:0]       req_flags,
  output logic                  sel_valid,
  output logic [IDX_W-1:0]      sel_idx,
  output logic                  busy,
  output logic [IDX_W-1:0]      cur_box
);
  logic [NBOX-1:0]       cand;
  logic [NBOX*KEY_W-1:0] keys;
  logic                  win_valid;
  logic [IDX_W-1:0]      win_idx;
  logic                  start_acc;
  logic                  done_acc;
  logic                  done_ok;
  logic [NBOX-1:0]       clr_mask;

  tba_req_store #(.NBOX(NBOX)) u_store (
    .clk(clk), .rst_n(rst_n), .set_mask(req_set), .clr_mask(clr_mask), .flags(req_flags)
  );

  tba_key_gen #(.NBOX(NBOX)) u_keys (
    .flags(req_flags), .box_cnt(box_cnt), .box_ext(box_ext), .box_id(box_id),
    .cand(cand), .keys(keys)
  );

  tba_scan #(.NBOX(NBOX)) u_scan (
    .cand(cand), .keys(keys), .win_valid(win_valid), .win_idx(win_idx)
  );

  assign sel_valid = win_valid && !busy;
  assign sel_idx   = win_idx;
  assign start_acc = tx_start && sel_valid;
  assign done_acc  = tx_done && busy;
  assign done_ok   = done_acc && tx_ok;
  assign clr_mask  = done_ok ? (NBOX'(1) << cur_box) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      cur_box <= '0;
    end else if (start_acc) begin
      busy    <= 1'b1;
      cur_box <= sel_idx;
    end else if (done_acc) begin
      busy    <= 1'b0;
    end
  end

  // R8
  start_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc |=> (busy && cur_box == $past(sel_idx)));

  // R8
  hold_box_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tx_done) |=> (busy && $stable(cur_box) && !sel_valid));

  // R9
  ok_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_ok && !req_set[cur_box]) |=> (!busy && !req_flags[$past(cur_box)]));

  // R10
  fail_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_acc && !tx_ok) |=> (!busy && req_flags[$past(cur_box)]));

  // R3
  sel_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> (int'(sel_idx) < int'(box_cnt) && req_flags[sel_idx]));

  // R12
  idle_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !sel_valid) |=> !busy);
endmodule

// File: tb/sim_tx_box_arbiter.sv
`timescale 1ns/1ps
module sim_tx_box_arbiter;
  localparam int NB = 16;
  localparam int IW = 29;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0] box_cnt = '0;
  logic [NB-1:0] box_ext;
  logic [NB*IW-1:0] box_id;
  logic [NB-1:0] req_set = '0;
  logic tx_start = 1'b0, tx_done = 1'b0, tx_ok = 1'b0;
  logic [NB-1:0] req_flags;
  logic sel_valid, busy;
  logic [3:0] sel_idx, cur_box;

  bit [IW-1:0] bid [NB];
  bit bext [NB];
  bit [NB-1:0] mflags;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  always_comb begin
    for (int i = 0; i < NB; i++) begin
      box_id[i*IW +: IW] = bid[i];
      box_ext[i] = bext[i];
    end
  end

  tx_box_arbiter u0 (
    .clk(clk), .rst_n(rst_n), .box_cnt(box_cnt), .box_ext(box_ext), .box_id(box_id),
    .req_set(req_set), .tx_start(tx_start), .tx_done(tx_done), .tx_ok(tx_ok),
    .req_flags(req_flags), .sel_valid(sel_valid), .sel_idx(sel_idx),
    .busy(busy), .cur_box(cur_box)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Arithmetic rank: top 11 bits weigh most, then short-before-long, then low 18 bits.
  function automatic longint rank(input int i);
    if (bext[i]) return (longint'(bid[i]) / 262144) * 524288 + 262144 + (longint'(bid[i]) % 262144);
    return (longint'(bid[i]) % 2048) * 524288;
  endfunction

  function automatic int model_win();
    int w = -1;
    for (int i = 0; i < NB; i++)
      if (mflags[i] && i < int'(box_cnt))
        if (w < 0 || rank(i) < rank(w)) w = i;
    return w;
  endfunction

  task automatic check_sel(input string tag);
    int w = model_win();
    #1;
    chk({tag, " valid"}, sel_valid, (w >= 0) ? 1 : 0);
    if (w >= 0) chk({tag, " index"}, sel_idx, w);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; req_set = '0; tx_start = 0; tx_done = 0;
    @(negedge clk); rst_n = 1'b1; mflags = '0;
  endtask

  task automatic load(input bit [NB-1:0] pat);
    @(negedge clk); req_set = pat;
    @(negedge clk); req_set = '0; mflags = mflags | pat;
  endtask

  task automatic send_one(input bit ok, input string tag);
    int w = model_win();
    @(negedge clk); tx_start = 1;
    @(negedge clk); tx_start = 0; #1;
    chk({tag, " R8 busy"}, busy, 1);
    chk({tag, " R8 cur_box"}, cur_box, w);
    chk({tag, " R8 no offer while busy"}, sel_valid, 0);
    tx_done = 1; tx_ok = ok;
    @(negedge clk); tx_done = 0; tx_ok = 0;
    if (ok) mflags[w] = 1'b0;
    #1;
    chk({tag, " busy drops"}, busy, 0);
    chk({tag, " flags after outcome"}, req_flags, mflags);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NB; i++) begin bid[i] = '0; bext[i] = 0; end
    mflags = '0;
    repeat (2) @(negedge clk);
    #1;
    // R1 reset state
    chk("R1 flags", req_flags, 0);
    chk("R1 busy", busy, 0);
    chk("R1 sel_valid", sel_valid, 0);
    chk("R1 cur_box", cur_box, 0);
    rst_n = 1'b1;

    // Sweep: counts, formats, identifiers, flag patterns (R2 R3 R4 R5 R6 R7)
    for (int p = 0; p < 400; p++) begin
      int mode = p % 4;
      do_reset();
      for (int i = 0; i < NB; i++) begin
        bext[i] = $urandom_range(0, 1);
        case (mode)
          0: bid[i] = IW'($urandom);
          1: bid[i] = IW'($urandom_range(0, 3)) << 18 | IW'($urandom_range(0, 1));
          2: bid[i] = bext[i] ? (IW'($urandom_range(0, 2)) << 18) | IW'($urandom_range(0, 2))
                              : IW'($urandom_range(0, 2));
          default: begin bid[i] = IW'(7) << 18; bext[i] = 1; end
        endcase
      end
      box_cnt = 5'(p % 20);
      load(NB'($urandom));
      #1 chk("R2 flags latched", req_flags, mflags);
      check_sel("R3 R4 R5 R6 R7 sweep");
    end

    // R5 short beats long with equal top bits
    do_reset(); box_cnt = 16;
    for (int i = 0; i < NB; i++) begin bid[i] = '1; bext[i] = 1; end
    bid[0] = IW'(12'h155) << 18; bext[0] = 1;
    bid[1] = IW'(11'h155); bext[1] = 0;
    load(16'h0003);
    #1 chk("R5 short over long", sel_idx, 1);
    // R6 equal identifiers, lower index wins
    do_reset();
    bid[2] = IW'(100); bext[2] = 0; bid[5] = IW'(100); bext[5] = 0;
    load(16'h0024);
    #1 chk("R6 tie lower index", sel_idx, 2);
    // R4 MSB-first zero wins
    do_reset();
    bid[3] = IW'(11'h400); bext[3] = 0; bid[4] = IW'(11'h3FF); bext[4] = 0;
    load(16'h0018);
    #1 chk("R4 msb decides", sel_idx, 4);
    // R7 combinational offer tracks count change
    box_cnt = 4; #1 chk("R7 R3 count shrinks", sel_idx, 3);
    box_cnt = 3; #1 chk("R3 count excludes", sel_valid, 0);

    // Drain in priority order (R8 R9)
    do_reset(); box_cnt = 16;
    for (int i = 0; i < NB; i++) begin bid[i] = IW'((i * 7) % 16) << 18; bext[i] = 1; end
    load(16'hFFFF);
    for (int k = 0; k < NB; k++) begin
      check_sel("R9 drain order");
      send_one(1'b1, "R9 drain");
    end
    check_sel("R9 drained");

    // R10 failure keeps the flag and re-offers
    do_reset(); load(16'h0300);
    send_one(1'b0, "R10 fail");
    check_sel("R10 reoffer");

    // R11 set on the same edge as success
    do_reset(); load(16'h0010);
    @(negedge clk); tx_start = 1;
    @(negedge clk); tx_start = 0; tx_done = 1; tx_ok = 1; req_set = 16'h0010;
    @(negedge clk); tx_done = 0; tx_ok = 0; req_set = '0; #1;
    chk("R11 flag kept", req_flags, 16'h0010);
    chk("R11 busy", busy, 0);

    // R12 start without offer, done while idle
    box_cnt = 0; #1;
    chk("R12 no offer", sel_valid, 0);
    @(negedge clk); tx_start = 1;
    @(negedge clk); tx_start = 0; #1;
    chk("R12 start ignored", busy, 0);
    tx_done = 1; tx_ok = 1;
    @(negedge clk); tx_done = 0; tx_ok = 0; #1;
    chk("R12 done ignored flags", req_flags, 16'h0010);
    chk("R12 done ignored busy", busy, 0);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule